// File: doc/BRIEF.md
# Message Byte Packer with Length Counter

This block sits between a memory-mapped message window and a hashing engine. Software or a DMA engine writes message bytes anywhere in the window, one to four bytes per beat, with the valid bytes marked by byte enables. The block gathers those bytes, in arrival order, into 32-bit words and places each word in a small word FIFO for the hash engine to pull. An optional swap reverses the order in which the lanes of each beat are taken. The block also keeps a running total of accepted bytes and reports it as a bit length for the padding stage.

A message opens with a start pulse and closes with a process pulse. On close, any bytes still waiting to fill a word are pushed as a final short word together with their count, so the padder knows where to put its marker. When the FIFO is full the write port stalls, and no data is lost or overwritten. Writes that arrive while the engine is disabled, before a start, or after the close are discarded and flagged on an error pulse.

Top module: `msg_packer`

## Requirements
- R1: The write address has no effect on what is packed; every address in the window feeds the same entry point.
- R2: With `swap_en` low, the enabled lanes of a beat are taken from lane 0 upward, and the first byte of each group of four lands in bits 31:24 of the pushed word. For a 3-lane beat 0x010203 then a 2-lane beat 0x0405, the block pushes 0x03020105 and then a short word 0x00000004.
- R3: With `swap_en` high, lanes are taken from lane 3 downward. The same two beats push 0x01020304 and then a short word 0x00000005.
- R4: Only lanes whose byte enable is set contribute bytes. A beat with no enables set adds nothing to the stream or to the length.
- R5: While the FIFO holds its full depth of words, `fifo_full` is high and `wr_ready` is low. A stalled beat is accepted only after a word is drained, and no word is dropped or overwritten.
- R6: The FIFO holds 16 words and presents them in push order on `out_data`. A word built from four bytes carries `out_nbytes` = 4, and the head stays stable while `out_ready` is low.
- R7: `msg_bits` equals eight times the bytes accepted since the last accepted start. A start with `eng_en` high clears it to 0 on the next cycle.
- R8: On a process pulse during an open message, leftover bytes (1 to 3) are pushed as one word. The word is right-aligned with the earliest byte most significant, and `out_nbytes` gives the byte count. If no bytes are left over, nothing extra is pushed.
- R9: A write accepted by the port while `eng_en` is low is discarded. `wr_err` pulses high on the following cycle, and neither the FIFO nor `msg_bits` changes.
- R10: A write while no message is open (before a start, or after the process pulse) is discarded and flagged on `wr_err` the following cycle.
- R11: After reset, `out_valid`, `fifo_full` and `wr_err` are low, `wr_ready` is high and `msg_bits` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eng_en | input | 1 | Engine enable; writes are rejected while low |
| swap_en | input | 1 | Take the lanes of each beat from the highest lane down |
| cmd_start | input | 1 | Open a message and clear the length |
| cmd_process | input | 1 | Close the message and flush leftover bytes |
| wr_valid | input | 1 | Write beat present |
| wr_addr | input | AW | Window address, ignored |
| wr_data | input | 32 | Write data, lane n in bits 8n+7:8n |
| wr_be | input | 4 | Byte enables per lane |
| wr_ready | output | 1 | Beat accepted this cycle when high |
| wr_err | output | 1 | One-cycle pulse after a rejected beat |
| fifo_full | output | 1 | Word FIFO is full |
| out_valid | output | 1 | Head word available |
| out_ready | input | 1 | Downstream pops the head word |
| out_data | output | 32 | Head word |
| out_nbytes | output | 3 | Valid bytes in the head word (1 to 4) |
| msg_bits | output | 64 | Accepted message length in bits |

## Verification
The bench goes after beats that straddle a word boundary, because a packer that loses track of the leftover count would push words with bytes shifted or repeated. It uses sparse and empty byte-enable patterns, which a design counting lanes instead of enabled bytes would get wrong in both the data and the length. It holds the downstream idle until the FIFO fills and offers one more beat, so a design that overwrites the oldest entry or drops the beat shows up as a missing or out-of-order word. It also closes messages on aligned and unaligned lengths and with the FIFO full at close time, which catches a flush that pushes an empty word, places the short word left-aligned, or disappears.

// File: rtl/msg_packer.sv
module msg_packer #(
  parameter int DEPTH = 16,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eng_en,
  input  logic          swap_en,
  input  logic          cmd_start,
  input  logic          cmd_process,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [3:0]    wr_be,
  output logic          wr_ready,
  output logic          wr_err,
  output logic          fifo_full,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [31:0]   out_data,
  output logic [2:0]    out_nbytes,
  output logic [63:0]   msg_bits
);
  localparam int PW = $clog2(DEPTH);
  localparam int EW = 35;

  logic          active, flush_pend;
  logic [2:0]    cnt, n_in, total;
  logic [23:0]   pend, pend_nx;
  logic [31:0]   inb, full_word, part_word;
  logic [55:0]   cmb;
  logic [63:0]   byte_cnt;
  logic [EW-1:0] mem [DEPTH];
  logic [PW:0]   wptr, rptr;
  logic          push, pop;
  logic [EW-1:0] push_ent;
  logic          addr_unused;

  assign addr_unused = ^wr_addr;

  assign fifo_full  = (wptr - rptr) == (PW+1)'(DEPTH);
  assign out_valid  = wptr != rptr;
  assign {out_nbytes, out_data} = mem[rptr[PW-1:0]];
  assign wr_ready   = !fifo_full;
  assign msg_bits   = {byte_cnt[60:0], 3'b000};

  wire start_go = cmd_start && eng_en;
  wire wr_fire  = wr_valid && wr_ready;
  wire wr_ok    = wr_fire && eng_en && active && !start_go;
  wire flush_go = flush_pend && !fifo_full && !start_go;

  always_comb begin
    inb  = '0;
    n_in = '0;
    for (int i = 0; i < 4; i++) begin
      if (wr_be[swap_en ? 3 - i : i]) begin
        inb[8*n_in +: 8] = wr_data[8*(swap_en ? 3 - i : i) +: 8];
        n_in = n_in + 3'd1;
      end
    end
  end

  assign total     = cnt + n_in;
  assign cmb       = {32'b0, pend} | ({24'b0, inb} << (8*cnt));
  assign full_word = {cmb[7:0], cmb[15:8], cmb[23:16], cmb[31:24]};
  assign pend_nx   = (total >= 3'd4) ? cmb[55:32] : cmb[23:0];

  always_comb begin
    case (cnt)
      3'd1:    part_word = {24'b0, pend[7:0]};
      3'd2:    part_word = {16'b0, pend[7:0], pend[15:8]};
      3'd3:    part_word = {8'b0, pend[7:0], pend[15:8], pend[23:16]};
      default: part_word = '0;
    endcase
  end

  always_comb begin
    push     = 1'b0;
    push_ent = '0;
    if (wr_ok && total >= 3'd4) begin
      push     = 1'b1;
      push_ent = {3'd4, full_word};
    end else if (flush_go && cnt != 3'd0) begin
      push     = 1'b1;
      push_ent = {cnt, part_word};
    end
  end

  assign pop = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (push) mem[wptr[PW-1:0]] <= push_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr       <= '0;
      rptr       <= '0;
      active     <= 1'b0;
      flush_pend <= 1'b0;
      cnt        <= '0;
      pend       <= '0;
      byte_cnt   <= '0;
      wr_err     <= 1'b0;
    end else begin
      wr_err <= wr_fire && !wr_ok;
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      if (start_go) begin
        active     <= 1'b1;
        flush_pend <= 1'b0;
        cnt        <= '0;
        pend       <= '0;
        byte_cnt   <= '0;
      end else begin
        if (wr_ok) begin
          byte_cnt <= byte_cnt + 64'(n_in);
          cnt      <= (total >= 3'd4) ? total - 3'd4 : total;
          pend     <= pend_nx;
        end
        if (cmd_process && active) begin
          active     <= 1'b0;
          flush_pend <= 1'b1;
        end else if (flush_go) begin
          flush_pend <= 1'b0;
          cnt        <= '0;
          pend       <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/msg_packer_chk.sv
module msg_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        eng_en,
  input logic        cmd_start,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic        wr_err,
  input logic        fifo_full,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic [2:0]  out_nbytes,
  input logic [63:0] msg_bits
);
  p_nbytes_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_nbytes != 3'd0 && out_nbytes <= 3'd4));

  p_stall_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !out_ready) |=> (fifo_full && !wr_ready));

  p_hold_head_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_nbytes)));

  p_len_monotonic_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_start |=> (msg_bits >= $past(msg_bits)));

  p_len_whole_bytes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_bits[2:0] == 3'd0);

  p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && eng_en) |=> (msg_bits == 64'd0));

  p_disabled_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !eng_en) |=> wr_err);

  p_disabled_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !eng_en && !cmd_start) |=> $stable(msg_bits));
endmodule

bind msg_packer msg_packer_chk u_chk (.*);

// File: tb/sim_msg_packer.sv
module sim_msg_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eng_en = 1'b0, swap_en = 1'b0, cmd_start = 1'b0, cmd_process = 1'b0;
  logic        wr_valid = 1'b0;
  logic [9:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic        rdy = 1'b0;
  logic        wr_ready, wr_err, fifo_full, out_valid;
  logic [31:0] out_data;
  logic [2:0]  out_nbytes;
  logic [63:0] msg_bits;

  int tests = 0, fails = 0;
  bit done = 0, rand_rdy = 0;
  logic [34:0] got [$];

  logic [34:0] mq [$];
  logic [7:0]  mp [$];
  longint unsigned mbytes;
  bit mact, mflush, merr;

  always #2 clk = ~clk;

  msg_packer u0 (
    .clk(clk), .rst_n(rst_n), .eng_en(eng_en), .swap_en(swap_en),
    .cmd_start(cmd_start), .cmd_process(cmd_process),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .wr_ready(wr_ready), .wr_err(wr_err), .fifo_full(fifo_full),
    .out_valid(out_valid), .out_ready(rdy), .out_data(out_data),
    .out_nbytes(out_nbytes), .msg_bits(msg_bits));

  task automatic chk(string r, logic [63:0] a, logic [63:0] e);
    tests++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, a, e);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); mp.delete(); mbytes = 0; mact = 0; mflush = 0; merr = 0;
    end else begin
      automatic bit full_pre = (mq.size() >= 16);
      automatic bit sgo = cmd_start && eng_en;
      automatic bit fire = wr_valid && !full_pre;
      automatic bit ok = fire && eng_en && mact && !sgo;
      automatic logic [31:0] w;
      merr = fire && !ok;
      if (rdy && mq.size() > 0) void'(mq.pop_front());
      if (sgo) begin
        mact = 1; mflush = 0; mp.delete(); mbytes = 0;
      end else begin
        if (ok) begin
          for (int i = 0; i < 4; i++) begin
            automatic int l = swap_en ? 3 - i : i;
            if (wr_be[l]) begin mp.push_back(wr_data[8*l +: 8]); mbytes++; end
          end
          if (mp.size() >= 4) begin
            w = {mp[0], mp[1], mp[2], mp[3]};
            repeat (4) void'(mp.pop_front());
            mq.push_back({3'd4, w});
          end
        end
        if (cmd_process && mact) begin
          mact = 0; mflush = 1;
        end else if (mflush && !full_pre) begin
          if (mp.size() > 0) begin
            w = 0;
            foreach (mp[j]) w = (w << 8) | 32'(mp[j]);
            mq.push_back({3'(mp.size()), w});
          end
          mp.delete(); mflush = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 ready", wr_ready, mq.size() < 16);
      chk("R5 full", fifo_full, mq.size() == 16);
      chk("R6 valid", out_valid, mq.size() > 0);
      if (mq.size() > 0) chk("R6 head", {out_nbytes, out_data}, mq[0]);
      chk("R7 length", msg_bits, mbytes * 8);
      chk("R10 err", wr_err, merr);
      if (out_valid && rdy) got.push_back({out_nbytes, out_data});
    end
  end

  always @(posedge clk) begin
    #1;
    if (rand_rdy) rdy = 1'($urandom_range(0, 1));
  end

  task automatic step(int k = 1);
    repeat (k) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d, logic [3:0] be);
    wr_valid = 1; wr_addr = a; wr_data = d; wr_be = be;
    while (!wr_ready) step();
    step();
    wr_valid = 0;
  endtask

  task automatic start_msg(); cmd_start = 1; step(); cmd_start = 0; endtask
  task automatic proc_msg();  cmd_process = 1; step(); cmd_process = 0; endtask
  task automatic drain(); rdy = 1; step(30); rdy = 0; endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R11 reset state
    chk("R11 valid", out_valid, 0);
    chk("R11 full", fifo_full, 0);
    chk("R11 ready", wr_ready, 1);
    chk("R11 err", wr_err, 0);
    chk("R11 bits", msg_bits, 0);

    // R9 disabled engine
    wr(10'h004, 32'h11223344, 4'hF);
    chk("R9 err pulse", wr_err, 1);
    chk("R9 length", msg_bits, 0);
    chk("R9 fifo", out_valid, 0);

    // R10 before start
    eng_en = 1;
    wr(10'h008, 32'h55667788, 4'hF);
    chk("R10 err before start", wr_err, 1);

    // R2 vector, unaligned addresses
    got.delete();
    start_msg();
    wr(10'h03C, 32'h00010203, 4'b0111);
    wr(10'h105, 32'h00000405, 4'b0011);
    proc_msg();
    step(3);
    chk("R7 bits 40", msg_bits, 40);
    wr(10'h000, 32'hDEADBEEF, 4'hF);
    chk("R10 err after process", wr_err, 1);
    chk("R10 length kept", msg_bits, 40);
    drain();
    chk("R2 count", got.size(), 2);
    chk("R2 word", got[0], {3'd4, 32'h03020105});
    chk("R8 short word", got[1], {3'd1, 32'h00000004});

    // R3 vector with other addresses (R1)
    got.delete();
    swap_en = 1;
    start_msg();
    chk("R7 cleared", msg_bits, 0);
    wr(10'h3FF, 32'h00010203, 4'b0111);
    wr(10'h2A0, 32'h00000405, 4'b0011);
    proc_msg();
    drain();
    chk("R1 address ignored", got.size(), 2);
    chk("R3 word", got[0], {3'd4, 32'h01020304});
    chk("R3 short word", got[1], {3'd1, 32'h00000005});

    // R4 sparse and empty enables
    got.delete();
    swap_en = 0;
    start_msg();
    wr(10'h010, 32'hAABBCCDD, 4'b1010);
    wr(10'h014, 32'hFFFFFFFF, 4'b0000);
    wr(10'h018, 32'h44332211, 4'b1111);
    proc_msg();
    drain();
    chk("R4 word", got[0], {3'd4, 32'hCCAA1122});
    chk("R4 short", got[1], {3'd2, 32'h00003344});
    chk("R4 length", msg_bits, 48);

    // R8 aligned close
    got.delete();
    start_msg();
    wr(10'h0, 32'h11223344, 4'hF);
    wr(10'h0, 32'h55667788, 4'hF);
    proc_msg();
    drain();
    chk("R8 no extra word", got.size(), 2);
    chk("R8 word", got[0], {3'd4, 32'h44332211});

    // R5 back-pressure with a full FIFO
    got.delete();
    start_msg();
    for (int i = 0; i < 16; i++) wr(10'(i), 32'h0A0B0C00 | 32'(i), 4'hF);
    chk("R5 full flag", fifo_full, 1);
    chk("R5 stall", wr_ready, 0);
    fork
      wr(10'h1, 32'h0A0B0C10, 4'hF);
      begin
        step(4);
        chk("R5 still stalled", wr_ready, 0);
        rdy = 1;
      end
    join
    wr(10'h2, 32'h000000AB, 4'b0001);
    rdy = 0;
    step(2);
    proc_msg();
    drain();
    chk("R6 count", got.size(), 18);
    for (int i = 0; i < 17; i++)
      chk("R6 order", got[i], {3'd4, 8'(i), 24'h0C0B0A});
    chk("R8 flush after full", got[17], {3'd1, 32'h000000AB});

    // random traffic against the reference model
    rand_rdy = 1;
    for (int m = 0; m < 30; m++) begin
      swap_en = 1'($urandom_range(0, 1));
      start_msg();
      for (int k = 0; k < int'($urandom_range(0, 40)); k++)
        wr(10'($urandom), $urandom, 4'($urandom));
      proc_msg();
      step(int'($urandom_range(0, 3)));
    end
    rand_rdy = 0;
    step();
    drain();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule